// File: doc/BRIEF.md
# Pipelined Bank Drain Chain (Gather and Reduce)

This block empties a row of on-chip result banks into one output word stream for a single write port. It has no wide multiplexer spanning every bank. The banks are split into equal groups, and each group has its own stage. Each stage talks only to the banks next to it. Stages are linked in a line by small FIFOs, so every hop covers a short distance and the number of banks can grow without making the output path longer.

One start pulse launches a batch, and a mode input sampled on that pulse picks one of two modes. In gather mode every word of every bank leaves in bank-major order. Each stage first passes on all the words that reach it from upstream, then appends the words of its own banks. In reduce mode each stage adds the values its banks hold at one address to the partial sum coming from upstream. The stream then carries one total per address.

The stream uses a valid/ready handshake and marks the closing word of each batch. While the consumer stalls, the stall spreads back through every FIFO and every stage. The bank contents belong to the current batch. The next batch can fill the other half of a double buffer while this one drains.

Top module: `grc_drain_chain`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid_o`, `busy_o` and every bit of `bank_rd_en_o` are low.
- R2: A `start_i` pulse while `busy_o` is low begins a batch in the mode given by `mode_i` on that cycle (0 = gather, 1 = reduce), and `busy_o` is high from the next cycle.
- R3: In gather mode the batch gives NUM_STAGES*BANKS_PER_STAGE*WORDS words: banks in rising index order, and inside each bank addresses 0 to WORDS-1 in rising order. Bank b is bit b of `bank_rd_en_o`.
- R4: In reduce mode the batch gives WORDS words. Word a is the sum, modulo 2^DATA_W, of the values at address a in all banks, with a rising from 0.
- R5: `out_last_o` is high on the final word of each batch and low on every other word. After that word is accepted, `out_valid_o` stays low until a new batch starts.
- R6: While `out_valid_o` is high and `out_ready_i` is low, the next cycle still offers the same word and last flag. No word is lost or repeated across stalls of any length.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The running batch keeps its mode and contents, and no extra batch follows.
- R8: A bank read enable is high only while `busy_o` is high. Its address sits in the bank's field of `bank_rd_addr_o` (bank b at bits b*AW upward, AW = clog2(WORDS)). The bank returns the data on `bank_rd_data_i` (bank b at bits b*DATA_W upward) on the next cycle and holds it until its next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Batch start pulse |
| mode_i | input | 1 | 0 gather, 1 reduce; sampled with start |
| busy_o | output | 1 | Batch in progress |
| bank_rd_en_o | output | NUM_STAGES*BANKS_PER_STAGE | Per-bank read enable |
| bank_rd_addr_o | output | NUM_STAGES*BANKS_PER_STAGE*AW | Per-bank read address |
| bank_rd_data_i | input | NUM_STAGES*BANKS_PER_STAGE*DATA_W | Per-bank read data, one cycle after enable |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer ready |
| out_data_o | output | DATA_W | Output word |
| out_last_o | output | 1 | Final word of the batch |

## Verification
The bench builds three stages of two banks, four words per bank, 8-bit data and two-entry FIFOs. With 8-bit data, random reduce sums overflow often, and an all-ones pattern exercises the modulo wrap in R4. With two-entry FIFOs, random and heavy consumer stalls fill every link, so backpressure reaches the forwarding phase and the bank-read phase of the middle and head stages. With three stages, the chain has a head stage, a middle stage and a tail stage, so upstream words get forwarded twice.

// File: rtl/grc_pkg.sv
package grc_pkg;

    typedef enum logic {
        MODE_GATHER = 1'b0,
        MODE_REDUCE = 1'b1
    } drain_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FWD,
        ST_ISSUE,
        ST_CAPT
    } stage_state_e;

    // index width that never collapses to zero
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/grc_fifo.sv
module grc_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int PW = grc_pkg::idx_w(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign data_o  = mem[rd_q];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/grc_stage.sv
module grc_stage
    import grc_pkg::*;
#(
    parameter int STAGE_IDX       = 0,
    parameter int NUM_STAGES      = 4,
    parameter int BANKS_PER_STAGE = 2,
    parameter int WORDS           = 4,
    parameter int DATA_W          = 16,
    parameter int FIFO_DEPTH      = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start_i,
    input  drain_mode_e                         mode_i,
    input  logic                                up_valid_i,
    input  logic [DATA_W:0]                     up_word_i,
    output logic                                up_pop_o,
    output logic [BANKS_PER_STAGE-1:0]          rd_en_o,
    output logic [idx_w(WORDS)-1:0]             rd_addr_o,
    input  logic [BANKS_PER_STAGE*DATA_W-1:0]   rd_data_i,
    output logic                                dn_valid_o,
    output logic [DATA_W:0]                     dn_word_o,
    input  logic                                dn_pop_i,
    output logic                                active_o
);
    localparam int  AW       = idx_w(WORDS);
    localparam int  BW       = idx_w(BANKS_PER_STAGE);
    localparam int  CW       = $clog2(NUM_STAGES * BANKS_PER_STAGE * WORDS + 1);
    localparam int  UP_WORDS = STAGE_IDX * BANKS_PER_STAGE * WORDS;
    localparam int  UP_LAST  = (UP_WORDS > 0) ? UP_WORDS - 1 : 0;
    localparam bit  HAS_UP   = (STAGE_IDX > 0);
    localparam bit  IS_TAIL  = (STAGE_IDX == NUM_STAGES - 1);

    stage_state_e state_q;
    drain_mode_e  mode_q;
    logic [CW-1:0] fwd_cnt_q;
    logic [BW-1:0] bank_q;
    logic [AW-1:0] addr_q;

    logic              issue_ok, fwd_fire, capt, own_end;
    logic              push, push_last, fifo_full, fifo_empty;
    logic [DATA_W-1:0] push_data, local_sum, picked, up_term;

    always_comb begin
        local_sum = '0;
        for (int j = 0; j < BANKS_PER_STAGE; j++)
            local_sum = local_sum + rd_data_i[j*DATA_W +: DATA_W];
    end

    assign picked  = rd_data_i[bank_q*DATA_W +: DATA_W];
    assign up_term = HAS_UP ? up_word_i[DATA_W-1:0] : '0;

    always_comb begin
        issue_ok = !fifo_full && (mode_q == MODE_GATHER || !HAS_UP || up_valid_i);
        fwd_fire = (state_q == ST_FWD) && up_valid_i && !fifo_full;
        capt     = (state_q == ST_CAPT);
        if (mode_q == MODE_GATHER)
            own_end = (bank_q == BW'(BANKS_PER_STAGE - 1)) && (addr_q == AW'(WORDS - 1));
        else
            own_end = (addr_q == AW'(WORDS - 1));
        push = fwd_fire || capt;
        if (fwd_fire)
            push_data = up_word_i[DATA_W-1:0];
        else if (mode_q == MODE_GATHER)
            push_data = picked;
        else
            push_data = local_sum + up_term;
        push_last = fwd_fire ? up_word_i[DATA_W] : (IS_TAIL && capt && own_end);
        up_pop_o  = fwd_fire || (capt && mode_q == MODE_REDUCE && HAS_UP);
        for (int j = 0; j < BANKS_PER_STAGE; j++)
            rd_en_o[j] = (state_q == ST_ISSUE) && issue_ok &&
                         (mode_q == MODE_REDUCE || bank_q == BW'(j));
    end

    assign rd_addr_o = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_GATHER;
            fwd_cnt_q <= '0;
            bank_q    <= '0;
            addr_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    mode_q    <= mode_i;
                    fwd_cnt_q <= '0;
                    bank_q    <= '0;
                    addr_q    <= '0;
                    state_q   <= (mode_i == MODE_GATHER && HAS_UP) ? ST_FWD : ST_ISSUE;
                end
                ST_FWD: if (fwd_fire) begin
                    fwd_cnt_q <= fwd_cnt_q + 1'b1;
                    if (fwd_cnt_q == CW'(UP_LAST)) state_q <= ST_ISSUE;
                end
                ST_ISSUE: if (issue_ok) state_q <= ST_CAPT;
                ST_CAPT: begin
                    if (own_end) begin
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_ISSUE;
                        if (mode_q == MODE_GATHER && addr_q == AW'(WORDS - 1)) begin
                            addr_q <= '0;
                            bank_q <= bank_q + 1'b1;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    grc_fifo #(.W(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_link (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .data_i  ({push_last, push_data}),
        .pop_i   (dn_pop_i),
        .data_o  (dn_word_o),
        .full_o  (fifo_full),
        .empty_o (fifo_empty)
    );

    assign dn_valid_o = !fifo_empty;
    assign active_o   = (state_q != ST_IDLE) || !fifo_empty;
endmodule

// File: rtl/grc_drain_chain.sv
module grc_drain_chain
    import grc_pkg::*;
#(
    parameter int NUM_STAGES      = 4,
    parameter int BANKS_PER_STAGE = 2,
    parameter int WORDS           = 4,
    parameter int DATA_W          = 16,
    parameter int FIFO_DEPTH      = 2
) (
    input  logic                                                   clk,
    input  logic                                                   rst,
    input  logic                                                   start_i,
    input  logic                                                   mode_i,
    output logic                                                   busy_o,
    output logic [NUM_STAGES*BANKS_PER_STAGE-1:0]                  bank_rd_en_o,
    output logic [NUM_STAGES*BANKS_PER_STAGE*idx_w(WORDS)-1:0]     bank_rd_addr_o,
    input  logic [NUM_STAGES*BANKS_PER_STAGE*DATA_W-1:0]           bank_rd_data_i,
    output logic                                                   out_valid_o,
    input  logic                                                   out_ready_i,
    output logic [DATA_W-1:0]                                      out_data_o,
    output logic                                                   out_last_o
);
    localparam int AW  = idx_w(WORDS);
    localparam int BPS = BANKS_PER_STAGE;

    logic [NUM_STAGES-1:0] lnk_valid;
    logic [DATA_W:0]       lnk_word [NUM_STAGES];
    logic [NUM_STAGES-1:0] lnk_pop;
    logic [NUM_STAGES-1:0] stage_active;
    logic                  head_pop_unused;
    logic                  launch;

    assign launch = start_i && !busy_o;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        logic              up_v;
        logic [DATA_W:0]   up_w;
        logic              up_pop;
        logic [AW-1:0]     st_addr;

        if (k == 0) begin : g_head
            assign up_v            = 1'b0;
            assign up_w            = '0;
            assign head_pop_unused = up_pop;
        end else begin : g_link
            assign up_v         = lnk_valid[k-1];
            assign up_w         = lnk_word[k-1];
            assign lnk_pop[k-1] = up_pop;
        end

        grc_stage #(
            .STAGE_IDX       (k),
            .NUM_STAGES      (NUM_STAGES),
            .BANKS_PER_STAGE (BPS),
            .WORDS           (WORDS),
            .DATA_W          (DATA_W),
            .FIFO_DEPTH      (FIFO_DEPTH)
        ) u_stage (
            .clk        (clk),
            .rst        (rst),
            .start_i    (launch),
            .mode_i     (drain_mode_e'(mode_i)),
            .up_valid_i (up_v),
            .up_word_i  (up_w),
            .up_pop_o   (up_pop),
            .rd_en_o    (bank_rd_en_o[k*BPS +: BPS]),
            .rd_addr_o  (st_addr),
            .rd_data_i  (bank_rd_data_i[k*BPS*DATA_W +: BPS*DATA_W]),
            .dn_valid_o (lnk_valid[k]),
            .dn_word_o  (lnk_word[k]),
            .dn_pop_i   (lnk_pop[k]),
            .active_o   (stage_active[k])
        );

        for (genvar j = 0; j < BPS; j++) begin : g_addr
            assign bank_rd_addr_o[(k*BPS + j)*AW +: AW] = st_addr;
        end
    end

    assign out_valid_o            = lnk_valid[NUM_STAGES-1];
    assign out_data_o             = lnk_word[NUM_STAGES-1][DATA_W-1:0];
    assign out_last_o             = lnk_valid[NUM_STAGES-1] & lnk_word[NUM_STAGES-1][DATA_W];
    assign lnk_pop[NUM_STAGES-1]  = out_valid_o & out_ready_i;
    assign busy_o                 = |stage_active;
endmodule

// File: rtl/grc_drain_chain_chk.sv
module grc_drain_chain_chk #(
    parameter int NUM_BANKS = 8,
    parameter int DATA_W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic                 busy_o,
    input logic [NUM_BANKS-1:0] bank_rd_en_o,
    input logic                 out_valid_o,
    input logic                 out_ready_i,
    input logic [DATA_W-1:0]    out_data_o,
    input logic                 out_last_o
);
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o |=> busy_o); // R2

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o)); // R6

    AST_QUIET_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        out_valid_o && out_ready_i && out_last_o |=> !out_valid_o); // R5

    AST_READS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> bank_rd_en_o == '0); // R8

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !out_valid_o); // R7
endmodule

bind grc_drain_chain grc_drain_chain_chk #(
    .NUM_BANKS (NUM_STAGES * BANKS_PER_STAGE),
    .DATA_W    (DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .bank_rd_en_o (bank_rd_en_o),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_data_o   (out_data_o),
    .out_last_o   (out_last_o)
);

// File: tb/grc_drain_chain_tb.sv
module grc_drain_chain_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 3;
    localparam int BPS = 2;
    localparam int W   = 4;
    localparam int DW  = 8;
    localparam int FD  = 2;
    localparam int NB  = NS * BPS;
    localparam int AW  = 2;
    localparam int WD_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic busy_o;
    logic [NB-1:0]    bank_rd_en_o;
    logic [NB*AW-1:0] bank_rd_addr_o;
    logic [NB*DW-1:0] bank_rd_data_i;
    logic out_valid_o;
    logic out_ready_i = 1'b0;
    logic [DW-1:0] out_data_o;
    logic out_last_o;

    int checks = 0;
    int errors = 0;
    int ready_pct = 100;
    bit done = 1'b0;

    logic [DW-1:0] mem [NB][W];
    logic [DW:0]   got [$];
    logic [DW:0]   expq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    grc_drain_chain #(
        .NUM_STAGES(NS), .BANKS_PER_STAGE(BPS), .WORDS(W), .DATA_W(DW), .FIFO_DEPTH(FD)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .busy_o(busy_o),
        .bank_rd_en_o(bank_rd_en_o), .bank_rd_addr_o(bank_rd_addr_o),
        .bank_rd_data_i(bank_rd_data_i), .out_valid_o(out_valid_o),
        .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_last_o(out_last_o)
    );

    // bank model: one-cycle read latency, data held until next read (R8)
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++)
            if (bank_rd_en_o[b])
                bank_rd_data_i[b*DW +: DW] <= mem[b][bank_rd_addr_o[b*AW +: AW]];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // consumer: random ready, capture accepted words, stall stability
    initial begin
        logic        stalled;
        logic [DW:0] held;
        stalled = 1'b0;
        held = '0;
        forever begin
            @(negedge clk);
            out_ready_i = (($urandom % 100) < ready_pct);
            #1;
            if (!rst) begin
                if (bank_rd_en_o != '0)
                    check(busy_o, "R8 read enable outside batch", int'(bank_rd_en_o), 0);
                if (stalled) begin
                    check(out_valid_o && {out_last_o, out_data_o} == held, "R6 stall hold",
                          int'({out_last_o, out_data_o}), int'(held));
                end
                if (out_valid_o && out_ready_i) got.push_back({out_last_o, out_data_o});
                stalled = out_valid_o && !out_ready_i;
                held = {out_last_o, out_data_o};
            end
        end
    end

    function automatic void build_expect(input bit red);
        expq.delete();
        if (!red) begin
            for (int b = 0; b < NB; b++)
                for (int a = 0; a < W; a++)
                    expq.push_back({1'b0, mem[b][a]});
        end else begin
            for (int a = 0; a < W; a++) begin
                logic [DW-1:0] s;
                s = '0;
                for (int b = 0; b < NB; b++) s = s + mem[b][a];
                expq.push_back({1'b0, s});
            end
        end
        expq[expq.size()-1][DW] = 1'b1;
    endfunction

    task automatic fill(input int kind);
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < W; a++)
                mem[b][a] = (kind == 1) ? '1 : DW'($urandom);
    endtask

    task automatic run_batch(input bit red, input int pct, input bit poke_busy);
        int wait_cyc;
        string tag;
        tag = red ? "R4" : "R3";
        build_expect(red);
        got.delete();
        ready_pct = pct;
        @(negedge clk);
        start_i = 1'b1;
        mode_i = red;
        @(negedge clk);
        start_i = 1'b0;
        mode_i = ~red;
        #2;
        check(busy_o, "R2 busy after start", int'(busy_o), 1);
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;      // R7: must be ignored
            mode_i = ~red;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_cyc = 0;
        while (busy_o && wait_cyc < 3000) begin
            @(negedge clk);
            #2;
            wait_cyc++;
        end
        repeat (4) @(negedge clk);
        check(got.size() == expq.size(), {tag, " word count"}, got.size(), expq.size());
        for (int i = 0; i < expq.size() && i < got.size(); i++) begin
            check(got[i][DW-1:0] == expq[i][DW-1:0], {tag, " word value"},
                  int'(got[i][DW-1:0]), int'(expq[i][DW-1:0]));
            check(got[i][DW] == expq[i][DW], "R5 last flag", int'(got[i][DW]), int'(expq[i][DW]));
        end
        if (poke_busy) begin
            check(!busy_o && !out_valid_o, "R7 no extra batch", int'(busy_o), 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < W; a++) mem[b][a] = '0;
        bank_rd_data_i = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid_o && !busy_o && bank_rd_en_o == '0, "R1 reset state",
              int'({out_valid_o, busy_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check(!out_valid_o && !busy_o && bank_rd_en_o == '0, "R1 after reset",
              int'({out_valid_o, busy_o}), 0);

        fill(0); run_batch(1'b0, 100, 1'b0);   // R3 gather, free-flowing
        fill(0); run_batch(1'b1, 100, 1'b0);   // R4 reduce
        fill(0); run_batch(1'b0, 60,  1'b0);   // R6 random stalls
        fill(1); run_batch(1'b1, 70,  1'b0);   // R4 wrap with all-ones
        fill(0); run_batch(1'b0, 15,  1'b1);   // R6 heavy stalls, R7 busy start
        fill(0); run_batch(1'b1, 15,  1'b1);   // R7 in reduce
        for (int n = 0; n < 6; n++) begin
            fill(0);
            run_batch(1'($urandom % 2), 20 + int'($urandom % 80), 1'($urandom % 2));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule